// File: doc/BRIEF.md
# GPIO Input-Change Interrupt Unit

This block raises a level interrupt when the input bus of a one- or two-channel GPIO changes. Each channel's input bus passes through a short synchronizer. The synchronized value is compared with the value one clock earlier. Any difference on any bit marks that channel pending. A pending channel can raise the interrupt line only if its enable bit is set and the global enable is on.

Software reaches the unit through a simple one-cycle register port. A write commits on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. Pending bits are toggled by writing ones, not cleared by writing ones. One write can therefore clear several channels, or set a channel by hand to test the interrupt path.

Each channel's pending bit is a two-state machine. `ST_QUIET` moves to `ST_PEND` on a detected change or on a toggle write. `ST_PEND` moves back to `ST_QUIET` on a toggle write, unless a change is detected in the same cycle. In that case it stays in `ST_PEND`. Every other combination holds the current state.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, the global-enable, pending and channel-enable registers all read 0, and `irq` is 0.
- R2: The global-enable register sits at offset 0x11C, with the flag in bit 31. Reads of bits 30..0 return 0, and writes to them are ignored.
- R3: The pending register sits at offset 0x120 and the channel-enable register at offset 0x128. In both, bit 0 is channel 1 and bit 1 is channel 2, and bits 31..2 read as 0.
- R4: A write to the pending register inverts each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A change on any bit of a channel's input bus sets that channel's pending bit. The change is seen three clock edges after the input changes: two synchronizer stages, then one compare stage. An input change held for a single clock is still captured.
- R6: `irq` is registered and active high. One clock after the registers update, it equals global enable AND (any pending bit whose enable bit is also set).
- R7: If a detected change and a toggle write hit the same pending bit in the same cycle, the bit ends up set.
- R8: Inputs held steady through reset cause no pending bit to be set after reset is released.
- R9: With `DUAL` = 0, bit 1 of the pending and enable registers always reads 0, and `ch2_in` has no effect.
- R10: Writes to any other offset change no register, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, committed on the clock edge |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Combinational read data |
| ch1_in | input | CH1_W | Channel 1 input bus |
| ch2_in | input | CH2_W | Channel 2 input bus |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench runs the clear/set collision in the exact cycle the pending bit loads. A design that gave priority to the toggle would lose that event and read 0. It flips each input bit alone and also pulses one bit for a single clock. A detector that compares only some bits, or samples too slowly, would leave a pending bit unset. It also checks the exact latency, where an extra or missing register would show the pending bit or `irq` one cycle off. It sweeps every combination of global enable, channel enables and pending bits. A masking error would raise or drop `irq` in the wrong case. A second instance built as single-channel checks that channel 2 stays silent.

// File: rtl/gci_pkg.sv
package gci_pkg;
    localparam logic [11:0] OFS_GIE = 12'h11C;
    localparam logic [11:0] OFS_ISR = 12'h120;
    localparam logic [11:0] OFS_IER = 12'h128;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_PEND  = 1'b1
    } pend_state_t;
endpackage

// File: rtl/gci_sync_detect.sv
module gci_sync_detect #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] pin,
    output logic         changed
);
    // The synchronizer and previous-sample flops run through reset, so the
    // previous sample already holds the settled input when reset releases.
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        stage_q[0] <= pin;
        for (int k = 1; k < STAGES; k++) begin
            stage_q[k] <= stage_q[k-1];
        end
        prev_q <= stage_q[STAGES-1];
    end

    assign changed = |(stage_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/gci_status_cell.sv
module gci_status_cell
    import gci_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic tog,
    output logic pend
);
    pend_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (hw_set || tog)  st_d = ST_PEND;
            ST_PEND:  if (tog && !hw_set) st_d = ST_QUIET;
            default:  st_d = ST_QUIET;
        endcase
    end

    assign pend = (st_q == ST_PEND);
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
    import gci_pkg::*;
#(
    parameter int CH1_W       = 8,
    parameter int CH2_W       = 4,
    parameter bit DUAL        = 1'b1,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CH1_W-1:0]  ch1_in,
    input  logic [CH2_W-1:0]  ch2_in,
    output logic              irq
);
    localparam int NCH     = DUAL ? 2 : 1;
    localparam int GIE_BIT = DATA_W - 1;
    localparam logic [ADDR_W-1:0] A_GIE = OFS_GIE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_ISR = OFS_ISR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_IER = OFS_IER[ADDR_W-1:0];

    logic [NCH-1:0] chg;
    logic [NCH-1:0] pend_v;
    logic [NCH-1:0] ier_q;
    logic           gie_q;
    logic           irq_q;

    // Change detection per channel
    gci_sync_detect #(.W(CH1_W), .STAGES(SYNC_STAGES)) u_det1 (
        .clk(clk), .pin(ch1_in), .changed(chg[0])
    );

    generate
        if (DUAL) begin : g_ch2
            gci_sync_detect #(.W(CH2_W), .STAGES(SYNC_STAGES)) u_det2 (
                .clk(clk), .pin(ch2_in), .changed(chg[NCH-1])
            );
        end else begin : g_no_ch2
            logic unused_ch2;
            assign unused_ch2 = ^ch2_in;
        end
    endgenerate

    // Write decode
    logic wr_gie, wr_isr, wr_ier;
    assign wr_gie = wr_en && (wr_addr == A_GIE);
    assign wr_isr = wr_en && (wr_addr == A_ISR);
    assign wr_ier = wr_en && (wr_addr == A_IER);

    logic unused_wbits;
    assign unused_wbits = ^wr_data[GIE_BIT-1:NCH];

    // Pending bits, one state machine per channel
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_cell
            gci_status_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .hw_set(chg[i]),
                .tog   (wr_isr && wr_data[i]),
                .pend  (pend_v[i])
            );
        end
    endgenerate

    // Enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            ier_q <= '0;
        end else begin
            if (wr_gie) gie_q <= wr_data[GIE_BIT];
            if (wr_ier) ier_q <= wr_data[NCH-1:0];
        end
    end

    // Registered interrupt output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= gie_q && (|(pend_v & ier_q));
    end
    assign irq = irq_q;

    // Read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_GIE)      rd_data[GIE_BIT] = gie_q;
        else if (rd_addr == A_ISR) rd_data[NCH-1:0] = pend_v;
        else if (rd_addr == A_IER) rd_data[NCH-1:0] = ier_q;
    end
endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk
    import gci_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [NCH-1:0]    chg,
    input logic [NCH-1:0]    pend,
    input logic [NCH-1:0]    ier,
    input logic              gie,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_GIE = OFS_GIE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_ISR = OFS_ISR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_IER = OFS_IER[ADDR_W-1:0];

    logic isr_wr;
    assign isr_wr = wr_en && (wr_addr == A_ISR);

    logic unused_chk;
    assign unused_chk = ^wr_data[DATA_W-1:NCH];

    a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_wr && chg == '0) |=> pend == $past(pend ^ wr_data[NCH-1:0]));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!isr_wr && chg == '0) |=> $stable(pend));

    a_r7_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((pend & $past(chg)) == $past(chg)));

    a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gie));

    a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && (pend & ier) != '0) |=> irq);

    a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie || (pend & ier) == '0) |=> !irq);

    a_r2_gie_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_GIE) |-> rd_data[DATA_W-2:0] == '0);

    a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_ISR || rd_addr == A_IER) |-> rd_data[DATA_W-1:NCH] == '0);
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .chg    (chg),
    .pend   (pend_v),
    .ier    (ier_q),
    .gie    (gie_q),
    .irq    (irq)
);

// File: tb/gpio_chg_irq_tb_top.sv
module gpio_chg_irq_tb_top;
    localparam logic [8:0] A_GIE = 9'h11C;
    localparam logic [8:0] A_ISR = 9'h120;
    localparam logic [8:0] A_IER = 9'h128;
    localparam logic [8:0] A_GAP = 9'h124;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [8:0]  rd_addr = '0;
    logic [31:0] rd_data, rd_data_s;
    logic [7:0]  ch1_in = 8'hA5;
    logic [3:0]  ch2_in = 4'h9;
    logic        irq, irq_s;

    int checks = 0;
    int errs = 0;
    bit finished = 1'b0;
    logic [31:0] v, vs;
    logic [1:0]  cur;

    always #5 clk = ~clk;

    gpio_chg_irq #(.CH1_W(8), .CH2_W(4), .DUAL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ch1_in(ch1_in), .ch2_in(ch2_in), .irq(irq)
    );

    gpio_chg_irq #(.CH1_W(8), .CH2_W(4), .DUAL(1'b0)) dut_s (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data_s), .ch1_in(ch1_in), .ch2_in(ch2_in), .irq(irq_s)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [8:0] a);
        rd_addr = a;
        #1;
        v = rd_data;
        vs = rd_data_s;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        tick(6);
        rst_n = 1'b1;
        tick(5);
        // R1 and R8: reset values, no false change with steady nonzero inputs
        rd(A_GIE); chk("R1 gie reset", v, 32'h0);
        rd(A_IER); chk("R1 ier reset", v, 32'h0);
        rd(A_ISR); chk("R8 isr after reset", v, 32'h0); chk("R8 isr after reset single", vs, 32'h0);
        chk("R1 irq reset", {31'h0, irq}, 32'h0);

        // R2 reserved bits and flag position
        wr(A_GIE, 32'h7FFF_FFFF); rd(A_GIE); chk("R2 gie low bits ignored", v, 32'h0);
        wr(A_GIE, 32'hFFFF_FFFF); rd(A_GIE); chk("R2 gie flag bit31", v, 32'h8000_0000);
        // R3 enable register layout
        wr(A_IER, 32'hFFFF_FFFF); rd(A_IER);
        chk("R3 ier readback", v, 32'h3); chk("R9 ier single", vs, 32'h1);
        // R10 unmapped offsets
        wr(A_GAP, 32'hFFFF_FFFF); wr(9'h000, 32'hFFFF_FFFF);
        rd(A_GAP); chk("R10 unmapped read", v, 32'h0);
        rd(A_ISR); chk("R10 isr untouched", v, 32'h0);
        rd(A_IER); chk("R10 ier untouched", v, 32'h3);
        rd(A_GIE); chk("R10 gie untouched", v, 32'h8000_0000);
        wr(A_GIE, 32'h0); wr(A_IER, 32'h0);

        // R4 toggle sweep over every start state and write value
        cur = 2'b00;
        for (int a = 0; a < 4; a++) begin
            for (int t = 0; t < 4; t++) begin
                wr(A_ISR, 32'hFFFF_FFF0 | {30'h0, cur ^ 2'(a)});
                cur = 2'(a);
                wr(A_ISR, 32'hFFFF_FFF0 | t);
                cur = cur ^ 2'(t);
                rd(A_ISR);
                chk("R4 toggle result", v, {30'h0, cur});
                chk("R9 toggle single", vs, {31'h0, cur[0]});
            end
        end
        wr(A_ISR, {30'h0, cur}); cur = 2'b00;

        // R5 exact latency on channel 1
        wr(A_GIE, 32'h8000_0000); wr(A_IER, 32'h1);
        ch1_in[0] = ~ch1_in[0];
        tick(2); rd(A_ISR); chk("R5 not yet set after two edges", v, 32'h0);
        tick(1); rd(A_ISR); chk("R5 set on third edge", v, 32'h1);
        chk("R6 irq not yet", {31'h0, irq}, 32'h0);
        tick(1); chk("R6 irq one clock later", {31'h0, irq}, 32'h1);
        wr(A_ISR, 32'h1);
        tick(1); chk("R6 irq drops after clear", {31'h0, irq}, 32'h0);
        wr(A_GIE, 32'h0); wr(A_IER, 32'h0);

        // R5 single-bit sweep over both channels
        for (int b = 0; b < 12; b++) begin
            logic [1:0] e;
            if (b < 8) begin ch1_in[b] = ~ch1_in[b]; e = 2'b01; end
            else       begin ch2_in[b-8] = ~ch2_in[b-8]; e = 2'b10; end
            tick(4);
            rd(A_ISR);
            chk("R5 bit flip sets channel", v, {30'h0, e});
            chk("R9 single ignores ch2", vs, {31'h0, e[0]});
            wr(A_ISR, {30'h0, e});
            rd(A_ISR); chk("R4 clear after flip", v, 32'h0);
        end

        // R5 all bits at once, and a one-clock pulse
        ch1_in = ~ch1_in; ch2_in = ~ch2_in;
        tick(4); rd(A_ISR); chk("R5 both channels", v, 32'h3);
        wr(A_ISR, 32'h3);
        ch2_in[1] = ~ch2_in[1]; tick(1); ch2_in[1] = ~ch2_in[1];
        tick(4); rd(A_ISR); chk("R5 one-clock pulse captured", v, 32'h2);
        wr(A_ISR, 32'h2);

        // R7 toggle write collides with hardware set
        wr(A_ISR, 32'h1);
        ch1_in[3] = ~ch1_in[3];
        tick(2);
        wr(A_ISR, 32'h1);
        rd(A_ISR); chk("R7 hardware set wins", v, 32'h1);
        wr(A_ISR, 32'h1);
        rd(A_ISR); chk("R7 cleared afterwards", v, 32'h0);

        // R6 mask sweep
        cur = 2'b00;
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < 4; e++) begin
                for (int s = 0; s < 4; s++) begin
                    wr(A_GIE, g[0] ? 32'h8000_0000 : 32'h0);
                    wr(A_IER, e);
                    wr(A_ISR, {30'h0, cur ^ 2'(s)});
                    cur = 2'(s);
                    tick(1);
                    chk("R6 irq mask", {31'h0, irq}, {31'h0, g[0] && ((e & s) != 0)});
                    chk("R9 irq mask single", {31'h0, irq_s}, {31'h0, g[0] && ((e & s & 1) != 0)});
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule